// File: doc/BRIEF.md
# Double-Buffered Calendar Register Window

This block puts a calendar clock into a bytewide 2K x 8 memory map. The top eight addresses of the map form a window of holding registers. The host reads and writes these registers. A separate set of live calendar counters keeps running outside the block. Every address below the window passes straight through to an ordinary SRAM port, so the host sees one flat memory.

The holding registers follow the counters only on a once-per-second tick, and only while both freeze bits in the control byte are clear. This way the host never reads a count in the middle of a change.

- **Read freeze:** setting the read-freeze bit holds the last captured time for as long as the bit stays set.
- **Write freeze:** setting the write-freeze bit also stops the copying, and it lets the host load new time fields.
- **Commit:** clearing the write-freeze bit sends the loaded values to the counters in a single-cycle load pulse.

The counters never stop while either freeze bit is set. The window also holds three other bits:

- an oscillator-stop control bit;
- a frequency-test control bit;
- a read-only battery-good flag.

Top module: `rtc_window`

## Requirements
- R1: Window byte offsets map to these registers: 0x7F8 century/control (bits 5:0 century, bit 6 read-freeze, bit 7 write-freeze), 0x7F9 seconds (bits 6:0, bit 7 oscillator stop), 0x7FA minutes (bits 6:0), 0x7FB hours (bits 5:0), 0x7FC weekday (bits 2:0, bit 6 frequency test, bit 7 battery flag), 0x7FD date (bits 5:0), 0x7FE month (bits 4:0), 0x7FF year (bits 7:0).
- R2: A host access below 0x7F8 asserts `sramSel` with the same address, write flag and write data. Read data for such an access is taken from `sramRdata` in the cycle after the request.
- R3: A window read returns its byte on `hostRdata` in the cycle after the request.
- R4: While both freeze bits are 0, each `secTick` copies the counter bytes into the time fields of the holding registers.
- R5: While read-freeze is 1, ticks do not change the holding time fields.
- R6: Host writes to time fields take effect only while write-freeze is already 1. At other times they are ignored, and no capture happens while write-freeze is 1.
- R7: A write of 0 to write-freeze while it is 1 produces a `cntLoad` pulse of exactly one cycle. The pulse appears the cycle after the write, with `cntLoadData` holding the time fields (byte i at bits 8i+7:8i).
- R8: The two freeze bits can be written at any time and read back in bits 7:6 of the control byte.
- R9: Oscillator stop (seconds bit 7, output `oscStop`) and frequency test (weekday bit 6, output `freqTest`) can be written at any time. Captures never change them.
- R10: Weekday bit 7 always reads the `batteryOk` input. Writes to it have no effect.
- R11: Unused bit positions always read 0, whatever value was written.
- R12: While frequency test is 1 and oscillator stop is 0, seconds bit 0 reads the `ftSquare` input.
- R13: After reset all holding bits and both freeze bits are 0, and `cntLoad` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host access request |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W | Byte address |
| hostWdata | input | 8 | Write data |
| hostRdata | output | 8 | Read data, one cycle after request |
| sramSel | output | 1 | SRAM access request |
| sramWr | output | 1 | SRAM write flag |
| sramAddr | output | ADDR_W | SRAM address |
| sramWdata | output | 8 | SRAM write data |
| sramRdata | input | 8 | SRAM read data |
| cntTime | input | 64 | Live counter bytes, byte i at bits 8i+7:8i |
| secTick | input | 1 | One-second capture pulse |
| cntLoad | output | 1 | Counter load pulse |
| cntLoadData | output | 64 | Values to load into the counters |
| batteryOk | input | 1 | Battery-good status |
| ftSquare | input | 1 | Test square wave |
| oscStop | output | 1 | Oscillator stop control |
| freqTest | output | 1 | Frequency test control |

## Verification
The assertions assume the following about the inputs:
- the host presents at most one request per cycle;
- `secTick` is a single-cycle pulse;
- reset is asserted from time zero.

The stimulus drives all inputs on the falling edge and holds every request for one cycle only. Ticks are sent only between host requests. The bench checks every read result against a behavioural model, and on every clock it also checks the load pulse and the control outputs.

// File: rtl/rtcw_pkg.sv
package rtcw_pkg;
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);

  localparam int OFS_CENT  = 0;
  localparam int OFS_SEC   = 1;
  localparam int OFS_MIN   = 2;
  localparam int OFS_HOUR  = 3;
  localparam int OFS_WDAY  = 4;
  localparam int OFS_DATE  = 5;
  localparam int OFS_MONTH = 6;
  localparam int OFS_YEAR  = 7;

  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic [IDX_W-1:0] idx;
    logic [7:0]       wdata;
    logic             wrTime;
    logic             capture;
    logic             commit;
    logic             freezeRd;
    logic             freezeWr;
  } rtcw_strobe_t;

  function automatic logic [7:0] timeMask(input int i);
    case (i)
      OFS_CENT:  return 8'h3F;
      OFS_SEC:   return 8'h7F;
      OFS_MIN:   return 8'h7F;
      OFS_HOUR:  return 8'h3F;
      OFS_WDAY:  return 8'h07;
      OFS_DATE:  return 8'h3F;
      OFS_MONTH: return 8'h1F;
      default:   return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] ctrlMask(input int i);
    case (i)
      OFS_SEC:  return 8'h80;
      OFS_WDAY: return 8'h40;
      default:  return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/rtcw_ctrl.sv
module rtcw_ctrl
  import rtcw_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWdata,
  input  logic              secTick,
  output rtcw_strobe_t      st,
  output logic              rdWinQ
);
  localparam int BASE_I = (1 << ADDR_W) - NUM_REGS;
  localparam logic [ADDR_W-1:0] BASE = BASE_I[ADDR_W-1:0];

  logic winHit;
  logic freezeWrQ;
  logic freezeRdQ;
  logic ctrlWrite;

  assign winHit    = hostSel && (hostAddr >= BASE);
  assign ctrlWrite = winHit && hostWr && (hostAddr[IDX_W-1:0] == IDX_W'(OFS_CENT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freezeWrQ <= 1'b0;
      freezeRdQ <= 1'b0;
      rdWinQ    <= 1'b0;
    end else begin
      if (ctrlWrite) begin
        freezeWrQ <= hostWdata[7];
        freezeRdQ <= hostWdata[6];
      end
      if (hostSel && !hostWr) rdWinQ <= winHit;
    end
  end

  always_comb begin
    st          = '0;
    st.wrEn     = winHit && hostWr;
    st.rdEn     = winHit && !hostWr;
    st.idx      = hostAddr[IDX_W-1:0];
    st.wdata    = hostWdata;
    st.wrTime   = freezeWrQ;
    st.capture  = secTick && !freezeRdQ && !freezeWrQ;
    st.commit   = ctrlWrite && freezeWrQ && !hostWdata[7];
    st.freezeRd = freezeRdQ;
    st.freezeWr = freezeWrQ;
  end

  // R8: freeze bits follow the last control-byte write
  a_r8_freeze_follow: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrite |=> (st.freezeWr == $past(hostWdata[7])) && (st.freezeRd == $past(hostWdata[6])));

  // R8: freeze bits change only through a control-byte write
  a_r8_freeze_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWrite |=> $stable(st.freezeWr) && $stable(st.freezeRd));
endmodule

// File: rtl/rtcw_dpath.sv
module rtcw_dpath
  import rtcw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  rtcw_strobe_t          st,
  input  logic [NUM_REGS*8-1:0] cntTime,
  input  logic                  batteryOk,
  input  logic                  ftSquare,
  output logic [7:0]            rdByte,
  output logic                  cntLoad,
  output logic [NUM_REGS*8-1:0] cntLoadData,
  output logic                  oscStop,
  output logic                  freqTest
);
  logic [7:0] hold     [NUM_REGS];
  logic [7:0] holdNext [NUM_REGS];
  logic [NUM_REGS*8-1:0] timeFlat;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
    localparam logic [7:0] TM = timeMask(g);
    localparam logic [7:0] CM = ctrlMask(g);
    logic hit;
    logic [7:0] timePart;
    logic [7:0] ctrlPart;

    assign hit = st.wrEn && (st.idx == IDX_W'(g));

    always_comb begin
      timePart = hold[g] & TM;
      if (st.capture)         timePart = cntTime[g*8 +: 8] & TM;
      if (hit && st.wrTime)   timePart = st.wdata & TM;
      ctrlPart = hold[g] & CM;
      if (hit)                ctrlPart = st.wdata & CM;
      holdNext[g] = timePart | ctrlPart;
    end

    always_ff @(posedge clk) begin
      if (!rstN) hold[g] <= '0;
      else       hold[g] <= holdNext[g];
    end

    assign timeFlat[g*8 +: 8] = hold[g] & TM;

    // R11: bits outside the field and control masks stay 0
    a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
      (hold[g] & ~(TM | CM)) == 8'h00);
  end

  assign oscStop  = hold[OFS_SEC][7];
  assign freqTest = hold[OFS_WDAY][6];

  logic [7:0] rdMux;
  always_comb begin
    rdMux = hold[st.idx];
    if (st.idx == IDX_W'(OFS_CENT)) rdMux[7:6] = {st.freezeWr, st.freezeRd};
    if (st.idx == IDX_W'(OFS_SEC) && freqTest && !oscStop) rdMux[0] = ftSquare;
    if (st.idx == IDX_W'(OFS_WDAY)) rdMux[7] = batteryOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdByte      <= '0;
      cntLoad     <= 1'b0;
      cntLoadData <= '0;
    end else begin
      if (st.rdEn) rdByte <= rdMux;
      cntLoad <= st.commit;
      if (st.commit) cntLoadData <= timeFlat;
    end
  end

  // R7: load pulse lasts one cycle
  a_r7_load_single: assert property (@(posedge clk) disable iff (!rstN)
    cntLoad |=> !cntLoad);

  // R7: load follows a falling write-freeze bit
  a_r7_load_after_release: assert property (@(posedge clk) disable iff (!rstN)
    cntLoad |-> !st.freezeWr && $past(st.freezeWr));

  // R5: time fields hold while only read-freeze is set
  a_r5_read_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (st.freezeRd && !st.freezeWr && $past(st.freezeRd && !st.freezeWr)) |-> $stable(timeFlat));

  // R9: control bits change only on a host window write
  a_r9_ctrl_only_host: assert property (@(posedge clk) disable iff (!rstN)
    !$past(st.wrEn) |-> $stable(oscStop) && $stable(freqTest));
endmodule

// File: rtl/rtc_window.sv
module rtc_window
  import rtcw_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hostSel,
  input  logic                  hostWr,
  input  logic [ADDR_W-1:0]     hostAddr,
  input  logic [7:0]            hostWdata,
  output logic [7:0]            hostRdata,
  output logic                  sramSel,
  output logic                  sramWr,
  output logic [ADDR_W-1:0]     sramAddr,
  output logic [7:0]            sramWdata,
  input  logic [7:0]            sramRdata,
  input  logic [NUM_REGS*8-1:0] cntTime,
  input  logic                  secTick,
  output logic                  cntLoad,
  output logic [NUM_REGS*8-1:0] cntLoadData,
  input  logic                  batteryOk,
  input  logic                  ftSquare,
  output logic                  oscStop,
  output logic                  freqTest
);
  localparam int BASE_I = (1 << ADDR_W) - NUM_REGS;
  localparam logic [ADDR_W-1:0] BASE = BASE_I[ADDR_W-1:0];

  rtcw_strobe_t st;
  logic         rdWinQ;
  logic [7:0]   rdByte;

  rtcw_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .secTick(secTick),
    .st(st), .rdWinQ(rdWinQ)
  );

  rtcw_dpath dpath_i (
    .clk(clk), .rstN(rstN), .st(st), .cntTime(cntTime),
    .batteryOk(batteryOk), .ftSquare(ftSquare), .rdByte(rdByte),
    .cntLoad(cntLoad), .cntLoadData(cntLoadData),
    .oscStop(oscStop), .freqTest(freqTest)
  );

  assign sramSel   = hostSel && (hostAddr < BASE);
  assign sramWr    = hostWr;
  assign sramAddr  = hostAddr;
  assign sramWdata = hostWdata;
  assign hostRdata = rdWinQ ? rdByte : sramRdata;

  // R2: SRAM never selected for a window address
  a_r2_sram_range: assert property (@(posedge clk) disable iff (!rstN)
    sramSel |-> (sramAddr < BASE) && hostSel);
endmodule

// File: tb/rtc_window_tb.sv
module rtc_window_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSel = 1'b0, hostWr = 1'b0;
  logic [10:0] hostAddr = '0;
  logic [7:0] hostWdata = '0, hostRdata;
  logic sramSel, sramWr;
  logic [10:0] sramAddr;
  logic [7:0] sramWdata, sramRdata = 8'h00;
  logic [63:0] cntTime = '0;
  logic secTick = 1'b0;
  logic cntLoad;
  logic [63:0] cntLoadData;
  logic batteryOk = 1'b1, ftSquare = 1'b0;
  logic oscStop, freqTest;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_window dut_i (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .sramSel(sramSel), .sramWr(sramWr), .sramAddr(sramAddr),
    .sramWdata(sramWdata), .sramRdata(sramRdata), .cntTime(cntTime),
    .secTick(secTick), .cntLoad(cntLoad), .cntLoadData(cntLoadData),
    .batteryOk(batteryOk), .ftSquare(ftSquare), .oscStop(oscStop),
    .freqTest(freqTest)
  );

  // ---------------- behavioural reference model ----------------
  function automatic int fieldBits(int i);
    int m[8] = '{'h3F, 'h7F, 'h7F, 'h3F, 'h07, 'h3F, 'h1F, 'hFF};
    return m[i];
  endfunction
  function automatic int ctlBits(int i);
    return (i == 1) ? 'h80 : (i == 4) ? 'h40 : 0;
  endfunction

  int mh[8];
  int mW = 0, mR = 0, mLoad = 0, modelRd = 0;
  int mLoadData[8];

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mh[i]) begin mh[i] = 0; mLoadData[i] = 0; end
      mW = 0; mR = 0; mLoad = 0;
    end else begin
      int i;
      bit hit;
      hit = hostSel && (hostAddr >= 11'h7F8);
      i = int'(hostAddr[2:0]);
      if (hit && !hostWr) begin
        modelRd = mh[i];
        if (i == 0) modelRd = modelRd | (mW << 7) | (mR << 6);
        if (i == 1 && ((mh[1] & 'h80) == 0) && ((mh[4] & 'h40) != 0))
          modelRd = (modelRd & 'hFE) | int'(ftSquare);
        if (i == 4) modelRd = (modelRd & 'h7F) | (int'(batteryOk) << 7);
      end
      mLoad = (hit && hostWr && i == 0 && mW == 1 && !hostWdata[7]) ? 1 : 0;
      if (mLoad == 1) foreach (mh[k]) mLoadData[k] = mh[k] & fieldBits(k);
      if (secTick && mW == 0 && mR == 0)
        foreach (mh[k]) mh[k] = (mh[k] & ctlBits(k)) | (int'(cntTime[k*8 +: 8]) & fieldBits(k));
      if (hit && hostWr) begin
        mh[i] = (mh[i] & ~ctlBits(i)) | (int'(hostWdata) & ctlBits(i));
        if (mW == 1) mh[i] = (mh[i] & ~fieldBits(i)) | (int'(hostWdata) & fieldBits(i));
        if (i == 0) begin mW = int'(hostWdata[7]); mR = int'(hostWdata[6]); end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of registered outputs
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R7 cntLoad", int'(cntLoad), mLoad);
      if (mLoad == 1)
        for (int k = 0; k < 8; k++) chk("R7 cntLoadData", int'(cntLoadData[k*8 +: 8]), mLoadData[k]);
      chk("R9 oscStop", int'(oscStop), (mh[1] >> 7) & 1);
      chk("R9 freqTest", int'(freqTest), (mh[4] >> 6) & 1);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic hostWrite(logic [10:0] a, logic [7:0] d);
    @(negedge clk);
    hostSel = 1; hostWr = 1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostSel = 0; hostWr = 0;
  endtask

  int lastRd;
  task automatic hostRead(logic [10:0] a, string tag);
    @(negedge clk);
    hostSel = 1; hostWr = 0; hostAddr = a;
    @(negedge clk);
    hostSel = 0;
    lastRd = int'(hostRdata);
    if (a >= 11'h7F8) chk(tag, lastRd, modelRd);
  endtask

  task automatic tick();
    @(negedge clk); secTick = 1;
    @(negedge clk); secTick = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R13 reset state, R10 battery flag
    chk("R13 cntLoad after reset", int'(cntLoad), 0);
    hostRead(11'h7F8, "R13 control byte");  chk("R13 control literal", lastRd, 'h00);
    hostRead(11'h7FB, "R13 hours");         chk("R13 hours literal", lastRd, 'h00);
    hostRead(11'h7FC, "R10 weekday");       chk("R10 battery reads 1", lastRd, 'h80);

    // R4 capture with both freeze bits clear, R1 map order
    cntTime = {8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h45, 8'h20};
    tick();
    for (int k = 0; k < 8; k++) hostRead(11'h7F8 + 11'(k), "R1 R4 capture");
    hostRead(11'h7F9, "R4 seconds");        chk("R4 seconds literal", lastRd, 'h45);
    hostRead(11'h7FF, "R1 year");           chk("R1 year literal", lastRd, 'h99);
    hostRead(11'h7FC, "R1 weekday");        chk("R1 weekday literal", lastRd, 'h87);

    // R6 time write ignored while write-freeze clear
    hostWrite(11'h7FA, 8'h11);
    hostRead(11'h7FA, "R6 ignored write");  chk("R6 minutes kept", lastRd, 'h59);

    // R5 read freeze, R8 readback
    hostWrite(11'h7F8, 8'h40);
    hostRead(11'h7F8, "R8 control");        chk("R8 read bit", lastRd, 'h60);
    cntTime[15:8] = 8'h46;
    tick();
    hostRead(11'h7F9, "R5 frozen");         chk("R5 seconds frozen", lastRd, 'h45);
    hostWrite(11'h7F8, 8'h00);
    tick();
    hostRead(11'h7F9, "R4 resumed");        chk("R4 seconds refreshed", lastRd, 'h46);

    // R6/R11 writes under write-freeze, R7 commit
    hostWrite(11'h7F8, 8'h80);
    hostRead(11'h7F8, "R8 write bit");      chk("R8 write bit literal", lastRd, 'hA0);
    hostWrite(11'h7FB, 8'hFF);
    hostRead(11'h7FB, "R11 hours mask");    chk("R11 unused hours bits", lastRd, 'h3F);
    hostWrite(11'h7F8, 8'h91);
    hostRead(11'h7F8, "R6 century");        chk("R6 century written", lastRd, 'h91);
    hostWrite(11'h7FA, 8'h30);
    cntTime[23:16] = 8'h05;
    tick();
    hostRead(11'h7FA, "R6 no capture");     chk("R6 minutes loaded", lastRd, 'h30);
    hostWrite(11'h7F8, 8'h00);
    chk("R7 pulse", int'(cntLoad), 1);
    chk("R7 hours value", int'(cntLoadData[31:24]), 'h3F);
    chk("R7 minutes value", int'(cntLoadData[23:16]), 'h30);
    chk("R7 century value", int'(cntLoadData[7:0]), 'h11);
    @(negedge clk);
    chk("R7 pulse ends", int'(cntLoad), 0);

    // R9 control bits, R12 frequency test
    cntTime[15:8] = 8'h46;
    hostWrite(11'h7F9, 8'h80);
    chk("R9 osc set", int'(oscStop), 1);
    hostRead(11'h7F9, "R9 seconds");        chk("R9 seconds kept", lastRd, 'hC6);
    cntTime[15:8] = 8'h50;
    tick();
    chk("R9 osc survives capture", int'(oscStop), 1);
    hostRead(11'h7F9, "R9 capture");        chk("R9 seconds captured", lastRd, 'hD0);
    hostWrite(11'h7FC, 8'h40);
    hostRead(11'h7FC, "R9 weekday");        chk("R9 ft set", lastRd, 'hC7);
    ftSquare = 1;
    hostRead(11'h7F9, "R12 osc stopped");   chk("R12 no toggle when stopped", lastRd, 'hD0);
    hostWrite(11'h7F9, 8'h00);
    hostRead(11'h7F9, "R12 ft high");       chk("R12 bit0 follows square", lastRd, 'h51);
    ftSquare = 0;
    hostRead(11'h7F9, "R12 ft low");        chk("R12 bit0 low", lastRd, 'h50);

    // R10 battery flag
    batteryOk = 0;
    hostRead(11'h7FC, "R10 low");           chk("R10 flag low", lastRd, 'h47);
    hostWrite(11'h7FC, 8'h80);
    hostRead(11'h7FC, "R10 write");         chk("R10 write ignored", lastRd, 'h07);
    batteryOk = 1;

    // R2 SRAM passthrough
    @(negedge clk);
    hostSel = 1; hostWr = 1; hostAddr = 11'h123; hostWdata = 8'h5A;
    #1;
    chk("R2 sramSel", int'(sramSel), 1);
    chk("R2 sramAddr", int'(sramAddr), 'h123);
    chk("R2 sramWdata", int'(sramWdata), 'h5A);
    @(negedge clk);
    hostSel = 0; hostWr = 0;
    sramRdata = 8'hA5;
    hostRead(11'h7F7, "R2 read");           chk("R2 sram read data", lastRd, 'hA5);
    @(negedge clk);
    hostSel = 1; hostAddr = 11'h7FD; #1;
    chk("R2 window not sram", int'(sramSel), 0);
    @(negedge clk); hostSel = 0;
    chk("R3 window read data", int'(hostRdata), 'h31);

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule